// File: doc/BRIEF.md
# Masked condition-field lookup-table logic unit

This unit evaluates small programmable Boolean functions over condition-register material. It has three kinds of operand. A 4-bit destination field holds the current value and is also one of the function inputs. Two 4-bit source fields are the other inputs. An 8-bit immediate table defines a three-input function. A selector picks one of three operations, plus a pass-through code.

The single-bit operation applies the three-input table to one bit position, chosen by a bit selector, and rewrites only that bit. The three-input field operation applies the same table to all four bit positions at once. The two-input field operation takes its 4-bit table from the second source field and uses the first source and the old destination as the index. Both field operations obey a per-bit write mask: a position whose mask bit is clear keeps its old destination bit.

A caller presents the operands with a one-cycle valid strobe. The new field is captured on that clock edge and stays on the output until the next strobe. A done flag is high during the cycle that follows each strobe cycle. Strobes may arrive in consecutive cycles.

Top module: `cflut_unit`

## Requirements
- R1: After reset, resField is 4'b0000 and done is 0, and both stay so until the first strobe.
- R2: With opSel = 0 (single bit), the bit at position b = bitSel becomes tableImm[idx], where idx bit 2 = dstField[b], idx bit 1 = srcA[b] and idx bit 0 = srcB[b]. wrMask has no effect on this operation.
- R3: With opSel = 0, every bit position other than bitSel keeps its dstField value.
- R4: With opSel = 1 (three-input field), each position i with wrMask[i] = 1 becomes tableImm[idx], where idx bit 2 = dstField[i], idx bit 1 = srcA[i] and idx bit 0 = srcB[i].
- R5: With opSel = 1 or 2, each position i with wrMask[i] = 0 keeps dstField[i].
- R6: With opSel = 2 (two-input field), each position i with wrMask[i] = 1 becomes srcB[j], where j bit 1 = dstField[i] and j bit 0 = srcA[i]. tableImm has no effect on this operation.
- R7: With opSel = 3, the result equals dstField unchanged.
- R8: The result is captured on the rising edge where inValid = 1 and holds while inValid = 0.
- R9: done is 1 in exactly the cycles that follow a cycle with inValid = 1, so it stays high through back-to-back strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| inValid | input | 1 | Operand strobe, one cycle per operation |
| opSel | input | 2 | 0 single bit, 1 three-input field, 2 two-input field, 3 pass-through |
| bitSel | input | 2 | Bit position written by the single-bit operation |
| dstField | input | 4 | Old destination field, also a function input |
| srcA | input | 4 | First source field |
| srcB | input | 4 | Second source field; the table in the two-input operation |
| tableImm | input | 8 | Three-input function table |
| wrMask | input | 4 | Per-bit write enable for the field operations |
| resField | output | 4 | New destination field |
| done | output | 1 | High for the cycle after each strobe |

## Verification
Two things can happen in the same cycle. One is the done flag and result of an earlier strobe. The other is the capture of a new strobe, which may use a different operation. The bench provokes this by issuing long runs of back-to-back strobes that mix all four opcodes, with occasional one- and two-cycle gaps between them. Each expected result carries the cycle in which it was issued. In every cycle the monitor decides from that stamp alone whether done must be high and which result must be showing, and otherwise it demands the held value and a low done.

// File: rtl/cflut_pkg.sv
`timescale 1ns/1ps
package cflut_pkg;

  typedef enum logic [1:0] {
    OP_BIT  = 2'd0,
    OP_TRI  = 2'd1,
    OP_DUO  = 2'd2,
    OP_PASS = 2'd3
  } opSel_e;

  typedef struct packed {
    logic load;
    logic useBit;
    logic useTri;
    logic useDuo;
  } ctrlStrobes_t;

endpackage

// File: rtl/cflut_lane.sv
`timescale 1ns/1ps
// One bit position of the field operations: both table lookups and the
// masked merge with the old destination bit.
module cflut_lane #(
  parameter int TRI_TBL = 8,
  parameter int DUO_TBL = 4
) (
  input  logic               oldBit,
  input  logic               aBit,
  input  logic               bBit,
  input  logic               maskBit,
  input  logic [TRI_TBL-1:0] triTable,
  input  logic [DUO_TBL-1:0] duoTable,
  output logic               triOut,
  output logic               duoOut
);
  logic [2:0] triIdx;
  logic [1:0] duoIdx;

  always_comb begin
    triIdx = {oldBit, aBit, bBit};
    duoIdx = {oldBit, aBit};
    triOut = maskBit ? triTable[triIdx] : oldBit;
    duoOut = maskBit ? duoTable[duoIdx] : oldBit;
  end
endmodule

// File: rtl/cflut_ctrl.sv
`timescale 1ns/1ps
module cflut_ctrl
  import cflut_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         inValid,
  input  logic [1:0]   opSel,
  output ctrlStrobes_t strobes,
  output logic         done
);
  always_comb begin
    strobes      = '0;
    strobes.load = inValid;
    unique case (opSel_e'(opSel))
      OP_BIT:  strobes.useBit = 1'b1;
      OP_TRI:  strobes.useTri = 1'b1;
      OP_DUO:  strobes.useDuo = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) done <= 1'b0;
    else       done <= inValid;
  end
endmodule

// File: rtl/cflut_datapath.sv
`timescale 1ns/1ps
module cflut_datapath
  import cflut_pkg::*;
#(
  parameter int FIELD_W = 4,
  localparam int SEL_W   = $clog2(FIELD_W),
  localparam int TRI_TBL = 8,
  localparam int DUO_TBL = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobes_t       strobes,
  input  logic [SEL_W-1:0]   bitSel,
  input  logic [FIELD_W-1:0] dstField,
  input  logic [FIELD_W-1:0] srcA,
  input  logic [FIELD_W-1:0] srcB,
  input  logic [TRI_TBL-1:0] tableImm,
  input  logic [FIELD_W-1:0] wrMask,
  output logic [FIELD_W-1:0] resField
);
  logic [FIELD_W-1:0] triVec;
  logic [FIELD_W-1:0] duoVec;
  logic [FIELD_W-1:0] bitVec;
  logic [FIELD_W-1:0] nextField;
  logic [2:0]         bitIdx;
  logic               bitResult;

  generate
    for (genvar i = 0; i < FIELD_W; i++) begin : gLane
      cflut_lane #(.TRI_TBL(TRI_TBL), .DUO_TBL(DUO_TBL)) lane_i (
        .oldBit  (dstField[i]),
        .aBit    (srcA[i]),
        .bBit    (srcB[i]),
        .maskBit (wrMask[i]),
        .triTable(tableImm),
        .duoTable(srcB[DUO_TBL-1:0]),
        .triOut  (triVec[i]),
        .duoOut  (duoVec[i])
      );
    end
  endgenerate

  always_comb begin
    bitIdx    = {dstField[bitSel], srcA[bitSel], srcB[bitSel]};
    bitResult = tableImm[bitIdx];
  end

  generate
    for (genvar i = 0; i < FIELD_W; i++) begin : gBit
      assign bitVec[i] = (bitSel == SEL_W'(i)) ? bitResult : dstField[i];
    end
  endgenerate

  always_comb begin
    if (strobes.useBit)      nextField = bitVec;
    else if (strobes.useTri) nextField = triVec;
    else if (strobes.useDuo) nextField = duoVec;
    else                     nextField = dstField;
  end

  always_ff @(posedge clk) begin
    if (!rstN)             resField <= '0;
    else if (strobes.load) resField <= nextField;
  end
endmodule

// File: rtl/cflut_unit.sv
`timescale 1ns/1ps
module cflut_unit
  import cflut_pkg::*;
#(
  parameter int FIELD_W = 4,
  localparam int SEL_W   = $clog2(FIELD_W),
  localparam int TRI_TBL = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               inValid,
  input  logic [1:0]         opSel,
  input  logic [SEL_W-1:0]   bitSel,
  input  logic [FIELD_W-1:0] dstField,
  input  logic [FIELD_W-1:0] srcA,
  input  logic [FIELD_W-1:0] srcB,
  input  logic [TRI_TBL-1:0] tableImm,
  input  logic [FIELD_W-1:0] wrMask,
  output logic [FIELD_W-1:0] resField,
  output logic               done
);
  ctrlStrobes_t strobes;

  cflut_ctrl ctrl_i (
    .clk    (clk),
    .rstN   (rstN),
    .inValid(inValid),
    .opSel  (opSel),
    .strobes(strobes),
    .done   (done)
  );

  cflut_datapath #(.FIELD_W(FIELD_W)) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .bitSel  (bitSel),
    .dstField(dstField),
    .srcA    (srcA),
    .srcB    (srcB),
    .tableImm(tableImm),
    .wrMask  (wrMask),
    .resField(resField)
  );
endmodule

// File: rtl/cflut_chk.sv
`timescale 1ns/1ps
module cflut_chk #(
  parameter int FIELD_W = 4,
  localparam int SEL_W   = $clog2(FIELD_W),
  localparam int TRI_TBL = 8
) (
  input logic               clk,
  input logic               rstN,
  input logic               inValid,
  input logic [1:0]         opSel,
  input logic [SEL_W-1:0]   bitSel,
  input logic [FIELD_W-1:0] dstField,
  input logic [FIELD_W-1:0] srcA,
  input logic [FIELD_W-1:0] srcB,
  input logic [TRI_TBL-1:0] tableImm,
  input logic [FIELD_W-1:0] wrMask,
  input logic [FIELD_W-1:0] resField,
  input logic               done
);
  AST_DONE_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> done); // R9

  AST_NO_SPURIOUS_DONE: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !done); // R9

  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> $stable(resField)); // R8

  AST_MASK_PROTECTS: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && (opSel == 2'd1 || opSel == 2'd2)) |=>
      ((resField ^ $past(dstField)) & ~$past(wrMask)) == '0); // R5

  AST_SINGLE_BIT_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && opSel == 2'd0) |=>
      ((resField ^ $past(dstField)) & ~(FIELD_W'(1) << $past(bitSel))) == '0); // R3

  AST_PASS_COPIES: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && opSel == 2'd3) |=> resField == $past(dstField)); // R7
endmodule

bind cflut_unit cflut_chk #(.FIELD_W(FIELD_W)) chk_i (
  .clk     (clk),
  .rstN    (rstN),
  .inValid (inValid),
  .opSel   (opSel),
  .bitSel  (bitSel),
  .dstField(dstField),
  .srcA    (srcA),
  .srcB    (srcB),
  .tableImm(tableImm),
  .wrMask  (wrMask),
  .resField(resField),
  .done    (done)
);

// File: tb/cflut_unit_tb_top.sv
`timescale 1ns/1ps
module cflut_unit_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       inValid = 1'b0;
  logic [1:0] opSel = '0;
  logic [1:0] bitSel = '0;
  logic [3:0] dstField = '0;
  logic [3:0] srcA = '0;
  logic [3:0] srcB = '0;
  logic [7:0] tableImm = '0;
  logic [3:0] wrMask = '0;
  logic [3:0] resField;
  logic       done;

  typedef struct {
    logic [3:0] exp;
    int         stamp;
    string      tag;
  } item_t;

  item_t      sbQ[$];
  int         cyc = 0;
  int         nChecks = 0;
  int         nFails = 0;
  bit         monOn = 1'b0;
  bit         finished = 1'b0;
  logic [3:0] lastExp = '0;

  cflut_unit dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opSel(opSel),
    .bitSel(bitSel), .dstField(dstField), .srcA(srcA), .srcB(srcB),
    .tableImm(tableImm), .wrMask(wrMask), .resField(resField), .done(done)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [3:0] model(input logic [1:0] op, input logic [3:0] d,
      input logic [3:0] a, input logic [3:0] b, input logic [7:0] imm,
      input logic [3:0] m, input logic [1:0] s);
    logic [3:0] r;
    r = d;
    case (op)
      2'd0: r[s] = imm[{d[s], a[s], b[s]}];
      2'd1: for (int i = 0; i < 4; i++) if (m[i]) r[i] = imm[{d[i], a[i], b[i]}];
      2'd2: for (int i = 0; i < 4; i++) if (m[i]) r[i] = b[{d[i], a[i]}];
      default: r = d;
    endcase
    return r;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic strobe(input logic [1:0] op, input logic [3:0] d, input logic [3:0] a,
      input logic [3:0] b, input logic [7:0] imm, input logic [3:0] m,
      input logic [1:0] s, input string tag);
    item_t it;
    opSel = op; dstField = d; srcA = a; srcB = b; tableImm = imm; wrMask = m;
    bitSel = s; inValid = 1'b1;
    it.exp = model(op, d, a, b, imm, m, s);
    it.stamp = cyc;
    it.tag = tag;
    sbQ.push_back(it);
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic idle(input int n);
    inValid = 1'b0;
    dstField = 4'hF; srcA = 4'hF; srcB = 4'hF; tableImm = 8'hFF; wrMask = 4'hF;
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  endtask

  // Monitor: the item issued in the previous cycle must show now
  initial begin
    forever begin
      @(negedge clk);
      if (monOn) begin
        if (sbQ.size() > 0 && sbQ[0].stamp == cyc - 1) begin
          item_t it;
          it = sbQ.pop_front();
          check(done === 1'b1, "R9 done after strobe", int'(done), 1);
          check(resField === it.exp, it.tag, int'(resField), int'(it.exp));
          lastExp = it.exp;
        end else begin
          check(done === 1'b0, "R9 done idle", int'(done), 0);
          check(resField === lastExp, "R8 hold", int'(resField), int'(lastExp));
        end
      end
    end
  end

  initial begin
    #(5.0 * 150000);
    nChecks++;
    nFails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(resField === 4'h0, "R1 reset field", int'(resField), 0);
    check(done === 1'b0, "R1 reset done", int'(done), 0);
    rstN = 1'b1;
    monOn = 1'b1;
    idle(3);
    check(resField === 4'h0, "R1 field before first strobe", int'(resField), 0);

    // Single-bit form, mask zero must not block it
    strobe(2'd0, 4'b0000, 4'b1111, 4'b1111, 8'h08, 4'h0, 2'd2, "R2 bit idx3 mask0");
    strobe(2'd0, 4'b1111, 4'b0000, 4'b0000, 8'hEF, 4'h0, 2'd0, "R2 bit idx4 clear");
    strobe(2'd0, 4'b1010, 4'b0101, 4'b1111, 8'h00, 4'hF, 2'd3, "R3 bit other bits kept");
    strobe(2'd0, 4'b0110, 4'b1001, 4'b0011, 8'hFF, 4'h0, 2'd1, "R3 bit set one");
    idle(2);
    // Three-input field form
    strobe(2'd1, 4'b1111, 4'b1111, 4'b1111, 8'h80, 4'hF, 2'd0, "R4 tri and3 all ones");
    strobe(2'd1, 4'b1100, 4'b1010, 4'b0110, 8'h96, 4'hF, 2'd0, "R4 tri parity");
    strobe(2'd1, 4'b1010, 4'b0000, 4'b0000, 8'hFF, 4'h0, 2'd0, "R5 tri mask zero");
    strobe(2'd1, 4'b0000, 4'b1111, 4'b0000, 8'hFF, 4'b0101, 2'd0, "R5 tri partial mask");
    idle(1);
    // Two-input field form, table from srcB, imm must not matter
    strobe(2'd2, 4'b1100, 4'b1010, 4'b0110, 8'h00, 4'hF, 2'd0, "R6 duo xor table");
    strobe(2'd2, 4'b1100, 4'b1010, 4'b1000, 8'hFF, 4'hF, 2'd0, "R6 duo and table imm ignored");
    strobe(2'd2, 4'b0011, 4'b1111, 4'b0000, 8'hFF, 4'b1001, 2'd0, "R5 duo partial mask");
    // Pass-through
    strobe(2'd3, 4'b1011, 4'b0100, 4'b1111, 8'h55, 4'hF, 2'd3, "R7 pass");
    idle(2);

    // Mixed back-to-back traffic with short gaps
    for (int k = 0; k < 400; k++) begin
      logic [1:0] op;
      string      tg;
      op = 2'($urandom_range(0, 3));
      case (op)
        2'd0: tg = "R2 random bit";
        2'd1: tg = "R4 random tri";
        2'd2: tg = "R6 random duo";
        default: tg = "R7 random pass";
      endcase
      strobe(op, 4'($urandom), 4'($urandom), 4'($urandom), 8'($urandom),
             4'($urandom), 2'($urandom), tg);
      if ($urandom_range(0, 4) == 0) idle($urandom_range(1, 2));
    end
    idle(4);
    check(sbQ.size() == 0, "R9 all results seen", sbQ.size(), 0);
    summary();
  end
endmodule